// File: doc/BRIEF.md
# SPI Target Port with Select Resynchronization

This block is the target (slave) side of an SPI link, moving 8-bit words. An external controller drives the serial clock. The port brings the clock, the select line and the incoming data into the system clock domain through two-flop synchronizers, and finds clock edges on the synchronized copy. A single shift register sends its most significant bit first while it collects incoming bits. When a word is complete it moves into a receive holding register and a sticky completion flag rises. A write strobe loads the next outgoing word whenever no word is in flight.

Two settings set the timing. The polarity bit sets the idle level of the clock. The phase bit picks which edge samples the data and which edge advances it. When the mode field holds the select-control code, an active-low select input gates the port. Raising select releases the data-out driver at once, even in the middle of a word, and clears the bit counter so the next frame starts on a clean boundary. With any other mode code, select is ignored. A separate driver-enable input keeps the output released, so the port can run as a receiver only. Clearing the enable input also clears the bit counter.

Top module: `spi_tgt_port`

## Requirements
- R1: After reset, `rx_data` is 0, `xfer_done` and `rx_ovf` are 0, and `sdo_oe` is 0 while `en` is 0.
- R2: Incoming bits are taken most significant first. When the eighth bit of a word is sampled, the word is copied to `rx_data` (if the holding register is free) and `xfer_done` is set.
- R3: `sdo` always shows the top bit of the shift register. With `cke`=0 the first bit is valid before the first clock edge. Each later bit appears after the edge that follows a sampling edge.
- R4: With `cke`=1, data is sampled on the edge back to the idle level. The outgoing data advances on the edge away from idle, except on the first such edge of a word.
- R5: `cpol` gives the idle level of `sck_in` (0 = idle low, 1 = idle high). The edge away from idle is the leading edge, whichever direction that is.
- R6: With `mode` equal to 4'h4, `ssn_in` high clears the bit counter and drops any partial word. A full word in the next frame is then received intact.
- R7: `sdo_oe` equals `en & drv_en & (mode != 4'h4 | ~ssn_in)`, with no clock delay from `ssn_in`. With any mode code other than 4'h4, transfers complete whatever level `ssn_in` holds.
- R8: With `en` low, no word completes and the bit counter is held at zero. A word sent after `en` returns high is received intact.
- R9: `tx_wr` loads `tx_data` into the shift register only when no bit of a word has been sampled. A write in the middle of a word has no effect on the bits sent.
- R10: If a word completes while the holding register is still unread (no `rx_rd` pulse since the last load), `rx_ovf` is set and `rx_data` keeps its earlier value. `rx_rd` frees the register, and `ovf_clr` clears `rx_ovf`.
- R11: `xfer_done` stays set until a `flag_clr` pulse. If a new word completes in the same cycle as the pulse, the flag stays set.
- R12: With `drv_en` low, `sdo_oe` stays low and words are still received.
- R13: After a word completes, the shift register holds the received word. With no new `tx_wr`, that word is sent back in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Port enable |
| mode | input | 4 | Mode code; 4'h4 turns on select control |
| cpol | input | 1 | Clock idle level |
| cke | input | 1 | Edge select (0: sample on leading edge) |
| drv_en | input | 1 | Output driver permission |
| sck_in | input | 1 | External serial clock |
| ssn_in | input | 1 | Select, active low |
| sdi_in | input | 1 | Serial data in |
| tx_data | input | 8 | Word to send |
| tx_wr | input | 1 | Load strobe for `tx_data` |
| rx_rd | input | 1 | Holding register read strobe |
| flag_clr | input | 1 | Clears `xfer_done` |
| ovf_clr | input | 1 | Clears `rx_ovf` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Tri-state enable for `sdo` |
| rx_data | output | 8 | Received word |
| xfer_done | output | 1 | Word complete flag |
| rx_ovf | output | 1 | Overflow flag |

## Verification
The assertions assume that every level on `sck_in`, `ssn_in` and `sdi_in` lasts at least three system clocks, so no edge is lost in the synchronizers. They also assume that `cpol` changes only while the port is inactive, since a change would look like a clock edge. The bench keeps six system clocks between serial clock edges. It changes `cpol` only with select control on and `ssn_in` high, and it changes `sdi_in` only on the controller's shift edge. It drives `cke`=1 only with select control enabled.

// File: rtl/spi_tgt_pkg.sv
`timescale 1ns/1ps
package spi_tgt_pkg;

  typedef struct packed {
    logic sample;
    logic shift;
  } edge_ev_t;

  // Turn a pair of clock samples into sample/shift events for the chosen timing.
  function automatic edge_ev_t classify_edge(input logic sck_now, input logic sck_was,
                                             input logic cpol, input logic cke);
    logic lvl_now, lvl_was, lead, trail;
    edge_ev_t ev;
    lvl_now   = sck_now ^ cpol;
    lvl_was   = sck_was ^ cpol;
    lead      = lvl_now & ~lvl_was;
    trail     = ~lvl_now & lvl_was;
    ev.sample = cke ? trail : lead;
    ev.shift  = cke ? lead : trail;
    return ev;
  endfunction

  // Frame gate: select only counts when select control is on.
  function automatic logic port_gate(input logic en, input logic sel_ctl, input logic ssn);
    return en & (~sel_ctl | ~ssn);
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
`timescale 1ns/1ps
module spi_tgt_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_shifter.sv
`timescale 1ns/1ps
module spi_tgt_shifter
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          cpol,
  input  logic          cke,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic          sdo_bit,
  output logic          byte_done,
  output logic [DW-1:0] byte_val
);
  logic          sck_d;
  logic [CW-1:0] cnt;
  logic          held, held_v;
  logic [DW-1:0] sr;
  edge_ev_t      ev;
  logic          sample_ev, shift_ev, last_bit, idle, tx_load;

  assign ev        = classify_edge(sck_s, sck_d, cpol, cke);
  assign sample_ev = ev.sample;
  assign shift_ev  = ev.shift;
  assign last_bit  = (cnt == CW'(DW - 1));
  assign idle      = (cnt == '0) && !held_v;
  assign byte_done = active & sample_ev & last_bit;
  assign byte_val  = {sr[DW-2:0], sdi_s};
  assign tx_load   = tx_wr & idle & ~(active & sample_ev);
  assign sdo_bit   = sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cnt    <= '0;
      held   <= 1'b0;
      held_v <= 1'b0;
      sr     <= '0;
    end else begin
      sck_d <= sck_s;
      if (!active) begin
        cnt    <= '0;
        held_v <= 1'b0;
      end else if (sample_ev) begin
        if (last_bit) begin
          cnt    <= '0;
          held_v <= 1'b0;
          sr     <= byte_val;
        end else begin
          cnt    <= cnt + 1'b1;
          held   <= sdi_s;
          held_v <= 1'b1;
        end
      end else if (shift_ev && held_v) begin
        sr     <= {sr[DW-2:0], held};
        held_v <= 1'b0;
      end
      if (tx_load) sr <= tx_data;
    end
  end

  // R6
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0 && !held_v));
  // R9
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (sr == $past(tx_data)));
  // R3
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sample_ev && !shift_ev && !tx_load) |=> $stable(sr));
endmodule

// File: rtl/spi_tgt_rxbuf.sv
`timescale 1ns/1ps
module spi_tgt_rxbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [DW-1:0] byte_val,
  input  logic          rx_rd,
  input  logic          flag_clr,
  input  logic          ovf_clr,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          ovf
);
  logic full, room, load_ok, lost;

  assign room    = ~full | rx_rd;
  assign load_ok = byte_done & room;
  assign lost    = byte_done & ~room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      full    <= 1'b0;
      done    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (load_ok) rx_data <= byte_val;
      if (load_ok)    full <= 1'b1;
      else if (rx_rd) full <= 1'b0;
      if (byte_done)     done <= 1'b1;
      else if (flag_clr) done <= 1'b0;
      if (lost)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (!full || rx_rd)) |=> (rx_data == $past(byte_val)));
  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full && !rx_rd) |=> (ovf && $stable(rx_data)));
  // R11
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_done) |=> !done);
endmodule

// File: rtl/spi_tgt_port.sv
`timescale 1ns/1ps
module spi_tgt_port
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MODE_W   = 4,
  parameter logic [MODE_W-1:0] SEL_CODE = 4'h4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              cpol,
  input  logic              cke,
  input  logic              drv_en,
  input  logic              sck_in,
  input  logic              ssn_in,
  input  logic              sdi_in,
  input  logic [DW-1:0]     tx_data,
  input  logic              tx_wr,
  input  logic              rx_rd,
  input  logic              flag_clr,
  input  logic              ovf_clr,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [DW-1:0]     rx_data,
  output logic              xfer_done,
  output logic              rx_ovf
);
  logic          sck_s, ssn_s, sdi_s;
  logic          sel_ctl, active;
  logic          byte_done;
  logic [DW-1:0] byte_val;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_in, ssn_in, sdi_in}),
    .q    ({sck_s, ssn_s, sdi_s})
  );

  assign sel_ctl = (mode == SEL_CODE);
  assign active  = port_gate(en, sel_ctl, ssn_s);
  // Driver release uses the raw select pin so it takes effect at once.
  assign sdo_oe  = drv_en & port_gate(en, sel_ctl, ssn_in);

  spi_tgt_shifter #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .cpol     (cpol),
    .cke      (cke),
    .tx_wr    (tx_wr),
    .tx_data  (tx_data),
    .sdo_bit  (sdo),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  spi_tgt_rxbuf #(.DW(DW)) u_rxbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_done(byte_done),
    .byte_val (byte_val),
    .rx_rd    (rx_rd),
    .flag_clr (flag_clr),
    .ovf_clr  (ovf_clr),
    .rx_data  (rx_data),
    .done     (xfer_done),
    .ovf      (rx_ovf)
  );

  // R8
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !byte_done);
endmodule

// File: tb/spi_tgt_port_bench.sv
`timescale 1ns/1ps
module spi_tgt_port_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, cpol = 0, cke = 0, drv_en = 1;
  logic [3:0] mode = 4'h4;
  logic sck_in = 0, ssn_in = 1, sdi_in = 0;
  logic [7:0] tx_data = 0;
  logic tx_wr = 0, rx_rd = 0, flag_clr = 0, ovf_clr = 0;
  logic sdo, sdo_oe, xfer_done, rx_ovf;
  logic [7:0] rx_data;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_tgt_port u_spi_tgt_port (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cpol(cpol), .cke(cke),
    .drv_en(drv_en), .sck_in(sck_in), .ssn_in(ssn_in), .sdi_in(sdi_in),
    .tx_data(tx_data), .tx_wr(tx_wr), .rx_rd(rx_rd), .flag_clr(flag_clr),
    .ovf_clr(ovf_clr), .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data),
    .xfer_done(xfer_done), .rx_ovf(rx_ovf)
  );

  // Reference model: pin history, bit position, word under assembly, flags.
  bit   hist_sck[2], hist_ssn[2], hist_sdi[2];
  bit   prev_sck;
  int   pos;
  bit   pend_bit, pend;
  bit [7:0] word, m_rx;
  bit   m_full, m_done, m_ovf;

  initial begin
    hist_sck = '{0, 0}; hist_ssn = '{1, 1}; hist_sdi = '{0, 0};
    prev_sck = 0; pos = 0; pend = 0; pend_bit = 0; word = 0;
    m_rx = 0; m_full = 0; m_done = 0; m_ovf = 0;
  end

  always @(posedge clk) begin
    bit c, s, d, away_now, away_was, lead, trail, smp, shf, live, fin, fresh, free;
    bit [7:0] got;
    if (!rst_n) begin
      hist_sck = '{0, 0}; hist_ssn = '{1, 1}; hist_sdi = '{0, 0};
      prev_sck = 0; pos = 0; pend = 0; word = 0;
      m_rx = 0; m_full = 0; m_done = 0; m_ovf = 0;
    end else begin
      c = hist_sck[1]; s = hist_ssn[1]; d = hist_sdi[1];
      away_now = (c != cpol); away_was = (prev_sck != cpol);
      lead = away_now && !away_was; trail = !away_now && away_was;
      smp = cke ? trail : lead;
      shf = cke ? lead : trail;
      live = en && (mode != 4'h4 || !s);
      fresh = (pos == 0) && !pend;
      fin = 0; got = 0;
      if (!live) begin pos = 0; pend = 0; end
      else if (smp) begin
        if (pos == 7) begin fin = 1; got = {word[6:0], d}; word = got; pos = 0; pend = 0; end
        else begin pend_bit = d; pend = 1; pos++; end
      end else if (shf && pend) begin word = {word[6:0], pend_bit}; pend = 0; end
      if (tx_wr && fresh && !(live && smp)) word = tx_data;
      free = !m_full || rx_rd;
      if (fin && free) begin m_rx = got; m_full = 1; end
      else if (rx_rd) m_full = 0;
      if (fin) m_done = 1; else if (flag_clr) m_done = 0;
      if (fin && !free) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      prev_sck = c;
      hist_sck[1] = hist_sck[0]; hist_sck[0] = sck_in;
      hist_ssn[1] = hist_ssn[0]; hist_ssn[0] = ssn_in;
      hist_sdi[1] = hist_sdi[0]; hist_sdi[0] = sdi_in;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "rx_data", rx_data, m_rx);
      chk("R11", "xfer_done", {7'd0, xfer_done}, {7'd0, m_done});
      chk("R10", "rx_ovf", {7'd0, rx_ovf}, {7'd0, m_ovf});
      chk("R3", "sdo", {7'd0, sdo}, {7'd0, word[7]});
      chk("R7", "sdo_oe", {7'd0, sdo_oe},
          {7'd0, en && drv_en && (mode != 4'h4 || !ssn_in)});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_tx(logic [7:0] v);
    tx_data = v; tx_wr = 1; tick(1); tx_wr = 0;
  endtask

  task automatic ack();
    rx_rd = 1; flag_clr = 1; ovf_clr = 1; tick(1);
    rx_rd = 0; flag_clr = 0; ovf_clr = 0;
  endtask

  // Controller side of the link: nbits clock cycles, returns what it sampled.
  task automatic xfer(logic [7:0] mo, int nbits, output logic [7:0] mi);
    mi = 0;
    if (!cke) begin
      sdi_in = mo[7]; tick(H);
      for (int i = 0; i < nbits; i++) begin
        mi[7-i] = sdo; sck_in = ~cpol; tick(H);
        sck_in = cpol; if (i < 7) sdi_in = mo[6-i]; tick(H);
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        sck_in = ~cpol; sdi_in = mo[7-i]; tick(H);
        mi[7-i] = sdo; sck_in = cpol; tick(H);
      end
    end
  endtask

  task automatic frame(logic [7:0] mo, output logic [7:0] mi);
    ssn_in = 0; tick(H);
    xfer(mo, 8, mi);
    tick(H); ssn_in = 1; tick(H);
  endtask

  task automatic set_timing(logic p, logic e);
    cpol = p; cke = e; sck_in = p; tick(H);
  endtask

  initial begin
    logic [7:0] mi;
    tick(5); rst_n = 1; tick(1);
    // R1 reset state
    chk("R1", "rx_data", rx_data, 8'h00);
    chk("R1", "xfer_done", {7'd0, xfer_done}, 8'h00);
    chk("R1", "rx_ovf", {7'd0, rx_ovf}, 8'h00);
    chk("R1", "sdo_oe", {7'd0, sdo_oe}, 8'h00);
    en = 1; tick(4);

    // R2/R3: idle-low clock, sample on leading edge
    load_tx(8'h3C); frame(8'hA5, mi);
    chk("R2", "word in", rx_data, 8'hA5);
    chk("R3", "word out", mi, 8'h3C);
    chk("R2", "done", {7'd0, xfer_done}, 8'h01);
    ack();
    chk("R11", "done cleared", {7'd0, xfer_done}, 8'h00);

    // R5: idle-high clock
    set_timing(1, 0);
    load_tx(8'h81); frame(8'h5A, mi);
    chk("R5", "word in", rx_data, 8'h5A);
    chk("R5", "word out", mi, 8'h81);
    ack();

    // R4: trailing-edge sampling, both polarities
    set_timing(0, 1);
    load_tx(8'h7E); frame(8'hC3, mi);
    chk("R4", "word in", rx_data, 8'hC3);
    chk("R4", "word out", mi, 8'h7E);
    ack();
    set_timing(1, 1);
    load_tx(8'hF0); frame(8'h0F, mi);
    chk("R4", "word in cpol1", rx_data, 8'h0F);
    chk("R4", "word out cpol1", mi, 8'hF0);
    ack();
    set_timing(0, 0);

    // R6/R7: abort mid-word, immediate release, then clean resync
    load_tx(8'h55);
    ssn_in = 0; tick(H);
    xfer(8'hE7, 3, mi);
    chk("R7", "oe while selected", {7'd0, sdo_oe}, 8'h01);
    ssn_in = 1; #1;
    chk("R7", "oe released at once", {7'd0, sdo_oe}, 8'h00);
    tick(H);
    chk("R6", "no word from partial", {7'd0, xfer_done}, 8'h00);
    frame(8'h96, mi);
    chk("R6", "word after resync", rx_data, 8'h96);
    ack();

    // R10: second word while unread
    frame(8'h11, mi);
    frame(8'h22, mi);
    chk("R10", "overflow set", {7'd0, rx_ovf}, 8'h01);
    chk("R10", "earlier word kept", rx_data, 8'h11);
    ack();
    chk("R10", "overflow cleared", {7'd0, rx_ovf}, 8'h00);

    // R13: echo of the received word
    frame(8'h33, mi);
    ack();
    frame(8'h44, mi);
    chk("R13", "echo", mi, 8'h33);
    ack();

    // R9: write mid-word ignored
    load_tx(8'h5C);
    ssn_in = 0; tick(H);
    fork
      xfer(8'h01, 8, mi);
      begin tick(5 * H); tx_data = 8'hFF; tx_wr = 1; tick(1); tx_wr = 0; end
    join
    tick(H); ssn_in = 1; tick(H);
    chk("R9", "word out", mi, 8'h5C);
    ack();

    // R7: select ignored in another mode
    mode = 4'h0; tick(H);
    chk("R7", "oe with select high", {7'd0, sdo_oe}, 8'h01);
    xfer(8'h6B, 8, mi); tick(H);
    chk("R7", "word without select", rx_data, 8'h6B);
    ack();
    mode = 4'h4; tick(H);

    // R12: receive only
    drv_en = 0;
    ssn_in = 0; tick(H);
    chk("R12", "oe held low", {7'd0, sdo_oe}, 8'h00);
    xfer(8'hD2, 8, mi); tick(H); ssn_in = 1; tick(H);
    chk("R12", "word in", rx_data, 8'hD2);
    ack(); drv_en = 1;

    // R8: disabled port, then counter cleared mid-word by enable
    en = 0; tick(H);
    frame(8'hAA, mi);
    chk("R8", "no done while off", {7'd0, xfer_done}, 8'h00);
    chk("R8", "data kept while off", rx_data, 8'hD2);
    en = 1; tick(H);
    ssn_in = 0; tick(H);
    xfer(8'hFF, 5, mi);
    en = 0; tick(H); en = 1; tick(H);
    xfer(8'h69, 8, mi); tick(H); ssn_in = 1; tick(H);
    chk("R8", "word after enable cycle", rx_data, 8'h69);
    ack();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule